// File: doc/BRIEF.md
# Embedded TLB Address Translation with Zone Protection

This block translates effective addresses for an embedded processor whose translation buffer is filled by software. The buffer is fully associative and holds a parameterised number of entries (64 by default). Each entry stores a valid flag, an owner process ID, an effective page number, a real page number, a 3-bit page-size code, a 4-bit zone selector, and its own execute and write permission bits. Software fills entries through a single write port. The port writes one whole entry per clock.

A lookup presents an effective address, the current process ID, a user/supervisor flag, the access kind and a 32-bit zone protection word. The block compares the request against every entry in the same cycle and selects the lowest-numbered entry that matches. It then forms the real address from that entry. It also works out the access rights in two steps: first the 2-bit zone code that the entry selects, then, where the zone code calls for it, the entry's own permission bits. All results are registered and appear one clock after the request. The outputs are a hit flag, the matching index, the real address, the granted rights and a fault code. The fault code keeps a translation miss separate from a protection fault.

Top module: `emb_tlb_xlate`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high after that edge, together with all of its results. A cycle without a request leaves `rsp_valid` low after the next edge, and reset clears `rsp_valid`.
- R2: An entry whose valid flag is clear never matches. Reset clears the valid flags of all entries.
- R3: An entry whose stored process ID is zero matches any `req_pid`. Any other stored ID must equal `req_pid`.
- R4: A page-size code s gives a page of 2^(10+2s) bytes and the mask ~(size−1). An entry matches when (`req_ea` AND mask) equals its stored page number.
- R5: On a hit, `rsp_paddr` = (entry real page number AND mask) OR (`req_ea` AND NOT mask).
- R6: When several entries match, the lowest index wins, and `rsp_index` reports that index.
- R7: When no entry matches, `rsp_hit` = 0, `rsp_fault` = 2'b01 (miss) and `rsp_rights` = 3'b000.
- R8: The zone code of zone z (the entry's 4-bit selector) is read from `req_zpr[31-2z:30-2z]`. Zone 0 therefore sits in bits 31:30 and zone 15 in bits 1:0.
- R9: Zone code 0 in user mode grants no rights (3'b000) and faults every access kind. In supervisor mode it applies the entry permission check.
- R10: Zone code 1 applies the entry permission check in both modes. The entry check grants `rsp_rights` = {exec, write, 1} in the order {bit2 = execute, bit1 = write, bit0 = read}. It raises a protection fault (`rsp_fault` = 2'b10) for a fetch without execute permission and for a store without write permission. A load never faults.
- R11: Zone code 2 applies the entry permission check in user mode. In supervisor mode it grants every right (3'b111) with no fault.
- R12: Zone code 3 grants every right (3'b111) with no fault in both modes.
- R13: A write with `wr_en` high updates the entry `wr_idx` at the rising edge. A lookup in the same cycle sees the contents from before the write. Access codes are 2'b00 load, 2'b01 store and 2'b10 fetch, and 2'b11 is handled as a load. The fault code is 2'b00 when the access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Entry index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_pid | input | 8 | Owner process ID to store (0 = any) |
| wr_epn | input | 32 | Effective page number to store |
| wr_rpn | input | 32 | Real page number to store |
| wr_size | input | 3 | Page-size code to store |
| wr_zone | input | 4 | Zone selector to store |
| wr_exec | input | 1 | Execute permission to store |
| wr_write | input | 1 | Write permission to store |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_pid | input | 8 | Current process ID |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_acc | input | 2 | Access kind |
| req_zpr | input | 32 | Zone protection word |
| rsp_valid | output | 1 | Results valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_index | output | 6 | Index of the winning entry |
| rsp_paddr | output | 32 | Real address (meaningless on a miss) |
| rsp_rights | output | 3 | Granted rights {execute, write, read} |
| rsp_fault | output | 2 | 00 ok, 01 miss, 10 protection |

## Verification
Every lookup result is due exactly one rising edge after the request. A table write takes effect at the edge where it is presented, so only lookups in later cycles see it. The bench drives inputs on the falling edge. It computes the expected result from its own entry model before it applies that cycle's write to the model, and it samples the outputs on the next falling edge. The reference model scans all entries behaviourally and decodes the zone word by shifting. Each cycle it compares `rsp_valid` and, whenever that flag is high, all result fields. The compared fields include the same-cycle write case and the page-boundary addresses.

// File: rtl/emb_tlb_pkg.sv
package emb_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_MISS = 2'b01,
    FLT_PROT = 2'b10,
    FLT_RSVD = 2'b11
  } flt_e;

  localparam int PAGE_LOG2_MIN  = 10;
  localparam int PAGE_LOG2_STEP = 2;
  localparam int SZW            = 3;
  localparam int ZSW            = 4;
  localparam int ZPRW           = 2 * (1 << ZSW);
  localparam int RTW            = 3;
  localparam int RT_R           = 0;
  localparam int RT_W           = 1;
  localparam int RT_X           = 2;

endpackage

// File: rtl/emb_tlb_store.sv
module emb_tlb_store
  import emb_tlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int AW   = 32,
  parameter int PIDW = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_valid,
  input  logic [PIDW-1:0] wr_pid,
  input  logic [AW-1:0]   wr_epn,
  input  logic [AW-1:0]   wr_rpn,
  input  logic [SZW-1:0]  wr_size,
  input  logic [ZSW-1:0]  wr_zone,
  input  logic            wr_exec,
  input  logic            wr_write,
  output logic [N-1:0]    ent_valid,
  output logic [PIDW-1:0] ent_pid  [N],
  output logic [AW-1:0]   ent_epn  [N],
  output logic [AW-1:0]   ent_rpn  [N],
  output logic [SZW-1:0]  ent_size [N],
  output logic [ZSW-1:0]  ent_zone [N],
  output logic [N-1:0]    ent_exec,
  output logic [N-1:0]    ent_write
);

  logic [N-1:0] valid_n;

  always_comb begin
    valid_n = ent_valid;
    if (wr_en) valid_n[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_valid <= '0;
    else        ent_valid <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_pid[wr_idx]   <= wr_pid;
      ent_epn[wr_idx]   <= wr_epn;
      ent_rpn[wr_idx]   <= wr_rpn;
      ent_size[wr_idx]  <= wr_size;
      ent_zone[wr_idx]  <= wr_zone;
      ent_exec[wr_idx]  <= wr_exec;
      ent_write[wr_idx] <= wr_write;
    end
  end

  // R13
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_valid[$past(wr_idx)] == $past(wr_valid)));

endmodule

// File: rtl/emb_tlb_match.sv
module emb_tlb_match
  import emb_tlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int AW   = 32,
  parameter int PIDW = 8
) (
  input  logic [AW-1:0]   req_ea,
  input  logic [PIDW-1:0] req_pid,
  input  logic [N-1:0]    ent_valid,
  input  logic [PIDW-1:0] ent_pid  [N],
  input  logic [AW-1:0]   ent_epn  [N],
  input  logic [SZW-1:0]  ent_size [N],
  output logic [AW-1:0]   ent_mask [N],
  output logic [N-1:0]    match_vec
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic pid_ok;
    logic page_ok;
    assign ent_mask[g] = {AW{1'b1}} << (PAGE_LOG2_MIN + PAGE_LOG2_STEP * int'(ent_size[g]));
    assign pid_ok      = (ent_pid[g] == '0) || (ent_pid[g] == req_pid);
    assign page_ok     = (req_ea & ent_mask[g]) == ent_epn[g];
    assign match_vec[g] = ent_valid[g] && pid_ok && page_ok;
  end

endmodule

// File: rtl/emb_tlb_prio.sv
module emb_tlb_prio #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  match_vec,
  output logic          any_hit,
  output logic [IW-1:0] win_idx
);

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  logic [N-1:0] below_win;
  assign below_win = (N'(1) << win_idx) - N'(1);

  // R6
  win_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> match_vec[win_idx]);

  // R6
  win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((match_vec & below_win) == '0));

endmodule

// File: rtl/emb_tlb_zone.sv
module emb_tlb_zone
  import emb_tlb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic [ZSW-1:0]  zsel,
  input  logic [ZPRW-1:0] zpr,
  input  logic            user,
  input  acc_e            acc,
  input  logic            ent_exec,
  input  logic            ent_write,
  output logic [RTW-1:0]  rights,
  output logic            prot_fault
);

  logic [1:0] zcode;
  logic       deny_all;
  logic       grant_all;

  assign zcode = 2'(zpr >> (ZPRW - 2 - 2 * int'(zsel)));

  always_comb begin
    deny_all  = 1'b0;
    grant_all = 1'b0;
    unique case (zcode)
      2'b00: deny_all  = user;
      2'b01: grant_all = 1'b0;
      2'b10: grant_all = !user;
      2'b11: grant_all = 1'b1;
      default: grant_all = 1'b0;
    endcase
  end

  always_comb begin
    if (deny_all)       rights = '0;
    else if (grant_all) rights = '1;
    else begin
      rights       = '0;
      rights[RT_R] = 1'b1;
      rights[RT_W] = ent_write;
      rights[RT_X] = ent_exec;
    end
  end

  always_comb begin
    prot_fault = deny_all;
    if (acc == ACC_FETCH && !rights[RT_X]) prot_fault = 1'b1;
    if (acc == ACC_STORE && !rights[RT_W]) prot_fault = 1'b1;
  end

  // R12
  zone_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && zcode == 2'b11) |-> !prot_fault);

  // R10
  zone_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && zcode == 2'b01 && acc == ACC_FETCH && !ent_exec) |-> prot_fault);

  // R9
  zone_user_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && zcode == 2'b00 && user) |-> (prot_fault && rights == '0));

endmodule

// File: rtl/emb_tlb_xlate.sv
module emb_tlb_xlate
  import emb_tlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int AW   = 32,
  parameter int PIDW = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_valid,
  input  logic [PIDW-1:0] wr_pid,
  input  logic [AW-1:0]   wr_epn,
  input  logic [AW-1:0]   wr_rpn,
  input  logic [2:0]      wr_size,
  input  logic [3:0]      wr_zone,
  input  logic            wr_exec,
  input  logic            wr_write,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_ea,
  input  logic [PIDW-1:0] req_pid,
  input  logic            req_user,
  input  logic [1:0]      req_acc,
  input  logic [31:0]     req_zpr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IW-1:0]   rsp_index,
  output logic [AW-1:0]   rsp_paddr,
  output logic [2:0]      rsp_rights,
  output logic [1:0]      rsp_fault
);

  logic [N-1:0]    ent_valid;
  logic [PIDW-1:0] ent_pid  [N];
  logic [AW-1:0]   ent_epn  [N];
  logic [AW-1:0]   ent_rpn  [N];
  logic [SZW-1:0]  ent_size [N];
  logic [ZSW-1:0]  ent_zone [N];
  logic [N-1:0]    ent_exec;
  logic [N-1:0]    ent_write;
  logic [AW-1:0]   ent_mask [N];
  logic [N-1:0]    match_vec;
  logic            any_hit;
  logic [IW-1:0]   win_idx;
  logic [RTW-1:0]  zone_rights;
  logic            zone_fault;
  acc_e            acc;

  assign acc = acc_e'(req_acc);

  emb_tlb_store #(.N(N), .AW(AW), .PIDW(PIDW)) u_store (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_valid, .wr_pid, .wr_epn, .wr_rpn,
    .wr_size, .wr_zone, .wr_exec, .wr_write,
    .ent_valid, .ent_pid, .ent_epn, .ent_rpn, .ent_size, .ent_zone,
    .ent_exec, .ent_write
  );

  emb_tlb_match #(.N(N), .AW(AW), .PIDW(PIDW)) u_match (
    .req_ea, .req_pid, .ent_valid, .ent_pid, .ent_epn, .ent_size,
    .ent_mask, .match_vec
  );

  emb_tlb_prio #(.N(N)) u_prio (
    .clk, .rst_n, .match_vec, .any_hit, .win_idx
  );

  emb_tlb_zone u_zone (
    .clk, .rst_n,
    .chk_en     (req_valid && any_hit),
    .zsel       (ent_zone[win_idx]),
    .zpr        (req_zpr),
    .user       (req_user),
    .acc        (acc),
    .ent_exec   (ent_exec[win_idx]),
    .ent_write  (ent_write[win_idx]),
    .rights     (zone_rights),
    .prot_fault (zone_fault)
  );

  // next-state
  logic            hit_n;
  logic [IW-1:0]   index_n;
  logic [AW-1:0]   paddr_n;
  logic [2:0]      rights_n;
  flt_e            fault_n;
  logic [AW-1:0]   win_mask;

  assign win_mask = ent_mask[win_idx];

  always_comb begin
    hit_n   = any_hit;
    index_n = win_idx;
    paddr_n = (ent_rpn[win_idx] & win_mask) | (req_ea & ~win_mask);
    if (!any_hit) begin
      rights_n = '0;
      fault_n  = FLT_MISS;
    end else begin
      rights_n = zone_rights;
      fault_n  = zone_fault ? FLT_PROT : FLT_NONE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_hit    <= hit_n;
      rsp_index  <= index_n;
      rsp_paddr  <= paddr_n;
      rsp_rights <= rights_n;
      rsp_fault  <= fault_n;
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_fault == FLT_MISS && rsp_rights == '0));

  // R10
  prot_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_PROT) |-> rsp_hit);

endmodule

// File: tb/emb_tlb_xlate_bench.sv
`timescale 1ns/100ps
module emb_tlb_xlate_bench;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_valid, wr_exec, wr_write;
  logic [5:0]  wr_idx;
  logic [7:0]  wr_pid;
  logic [31:0] wr_epn, wr_rpn;
  logic [2:0]  wr_size;
  logic [3:0]  wr_zone;
  logic        req_valid, req_user;
  logic [31:0] req_ea, req_zpr;
  logic [7:0]  req_pid;
  logic [1:0]  req_acc;
  logic        rsp_valid, rsp_hit;
  logic [5:0]  rsp_index;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  emb_tlb_xlate u_emb_tlb_xlate (.*);

  // behavioural table model
  logic        m_v [N];
  logic [7:0]  m_pid [N];
  logic [31:0] m_epn [N];
  logic [31:0] m_rpn [N];
  logic [2:0]  m_sz [N];
  logic [3:0]  m_zn [N];
  logic        m_x [N];
  logic        m_w [N];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic e_v, e_h, denied;
    logic [5:0]  e_i;
    logic [31:0] e_pa, mask;
    logic [2:0]  e_rt;
    logic [1:0]  e_f;
    int zc;
    e_v = req_valid; e_h = 0; e_i = 0; e_pa = 0; e_rt = 0; e_f = 2'b01;
    if (req_valid) begin
      for (int i = 0; i < N; i++) begin
        mask = 32'hFFFF_FFFF << (10 + 2 * int'(m_sz[i]));
        if (!e_h && m_v[i] && (m_pid[i] == 0 || m_pid[i] == req_pid) &&
            ((req_ea & mask) == m_epn[i])) begin
          e_h  = 1;
          e_i  = 6'(i);
          e_pa = (m_rpn[i] & mask) | (req_ea & ~mask);
          zc   = int'((req_zpr >> (30 - 2 * int'(m_zn[i]))) & 32'h3);
          denied = (zc == 0) && req_user;
          if (zc == 3 || (zc == 2 && !req_user)) e_rt = 3'b111;
          else if (denied)                       e_rt = 3'b000;
          else                                   e_rt = {m_x[i], m_w[i], 1'b1};
          e_f = (denied || (req_acc == 2'b10 && !e_rt[2]) ||
                 (req_acc == 2'b01 && !e_rt[1])) ? 2'b10 : 2'b00;
        end
      end
    end
    if (wr_en) begin
      m_v[wr_idx] = wr_valid; m_pid[wr_idx] = wr_pid; m_epn[wr_idx] = wr_epn;
      m_rpn[wr_idx] = wr_rpn; m_sz[wr_idx] = wr_size; m_zn[wr_idx] = wr_zone;
      m_x[wr_idx] = wr_exec;  m_w[wr_idx] = wr_write;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", 32'(rsp_valid), 32'(e_v));
    if (e_v) begin
      check(tag, "rsp_hit", 32'(rsp_hit), 32'(e_h));
      check(tag, "rsp_fault", 32'(rsp_fault), 32'(e_f));
      check(tag, "rsp_rights", 32'(rsp_rights), 32'(e_rt));
      if (e_h) begin
        check(tag, "rsp_index", 32'(rsp_index), 32'(e_i));
        check(tag, "rsp_paddr", rsp_paddr, e_pa);
      end
    end
    req_valid = 0;
    wr_en = 0;
  endtask

  task automatic set_wr(input int idx, input logic v, input int pid,
                        input logic [31:0] epn, input logic [31:0] rpn,
                        input int sz, input int zn, input logic x, input logic w);
    wr_en = 1; wr_idx = 6'(idx); wr_valid = v; wr_pid = 8'(pid);
    wr_epn = epn; wr_rpn = rpn; wr_size = 3'(sz); wr_zone = 4'(zn);
    wr_exec = x; wr_write = w;
  endtask

  task automatic set_req(input logic [31:0] ea, input int pid, input logic user,
                         input int acc, input logic [31:0] zpr);
    req_valid = 1; req_ea = ea; req_pid = 8'(pid); req_user = user;
    req_acc = 2'(acc); req_zpr = zpr;
  endtask

  task automatic lookup(input string tag, input logic [31:0] ea, input int pid,
                        input logic user, input int acc, input logic [31:0] zpr);
    set_req(ea, pid, user, acc, zpr);
    step(tag);
  endtask

  task automatic put(input int idx, input logic v, input int pid,
                     input logic [31:0] epn, input logic [31:0] rpn,
                     input int sz, input int zn, input logic x, input logic w);
    set_wr(idx, v, pid, epn, rpn, sz, zn, x, w);
    step("R13");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    string ztag [4];
    ztag[0] = "R9"; ztag[1] = "R10"; ztag[2] = "R11"; ztag[3] = "R12";
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_pid[i] = 0; m_epn[i] = 0; m_rpn[i] = 0;
      m_sz[i] = 0; m_zn[i] = 0; m_x[i] = 0; m_w[i] = 0;
    end
    rst_n = 0; wr_en = 0; req_valid = 0;
    wr_idx = 0; wr_valid = 0; wr_pid = 0; wr_epn = 0; wr_rpn = 0;
    wr_size = 0; wr_zone = 0; wr_exec = 0; wr_write = 0;
    req_ea = 0; req_pid = 0; req_user = 0; req_acc = 0; req_zpr = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    step("R1");

    // R2: after reset nothing matches
    lookup("R2", 32'h0000_0000, 0, 0, 0, 32'hFFFF_FFFF);

    // table contents
    put(0,  1, 5, 32'h0001_0000, 32'h8000_0000, 1, 1,  1, 0);
    put(1,  1, 0, 32'h0002_0400, 32'h4000_0000, 0, 2,  0, 1);
    put(2,  1, 0, 32'h0030_0000, 32'h1234_0000, 3, 3,  0, 0);
    put(3,  1, 0, 32'h0030_0000, 32'h5678_0000, 3, 3,  1, 1);
    put(5,  0, 0, 32'h0050_0000, 32'h2000_0000, 2, 1,  1, 1);
    put(10, 1, 0, 32'h0100_0000, 32'hFF00_0000, 7, 15, 0, 0);
    put(63, 1, 9, 32'h0700_0000, 32'h0900_0000, 2, 0,  0, 0);

    // R3 process ID handling
    lookup("R3", 32'h0001_0010, 5, 0, 0, 32'h5555_5555);
    lookup("R3", 32'h0001_0010, 6, 0, 0, 32'h5555_5555);
    lookup("R3", 32'h0002_0410, 77, 0, 0, 32'h5555_5555);
    lookup("R3", 32'h0700_0004, 9, 0, 0, 32'h5555_5555);
    lookup("R3", 32'h0700_0004, 0, 0, 0, 32'h5555_5555);
    // R4 page boundaries
    lookup("R4", 32'h0001_0FFF, 5, 0, 0, 32'h5555_5555);
    lookup("R4", 32'h0001_1000, 5, 0, 0, 32'h5555_5555);
    lookup("R4", 32'h0002_07FF, 1, 0, 0, 32'h5555_5555);
    lookup("R4", 32'h0002_0800, 1, 0, 0, 32'h5555_5555);
    lookup("R4", 32'h01FF_FFFF, 1, 0, 0, 32'h5555_5555);
    // R5 address composition
    lookup("R5", 32'h0130_ABCD, 3, 0, 0, 32'h5555_5555);
    lookup("R5", 32'h0030_F00D, 3, 0, 0, 32'h5555_5555);
    // R6 overlapping entries 2 and 3
    lookup("R6", 32'h0030_1234, 0, 1, 1, 32'hFFFF_FFFF);
    // R2 invalid entry 5
    lookup("R2", 32'h0050_0040, 0, 0, 0, 32'hFFFF_FFFF);
    // R7 plain miss
    lookup("R7", 32'hDEAD_0000, 0, 0, 2, 32'hFFFF_FFFF);

    // zone code sweep on entry 0 (zone 1, exec only) and entry 1 (zone 2, write only)
    for (int code = 0; code < 4; code++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++) begin
          lookup(ztag[code], 32'h0001_0100, 5, u[0], a, 32'(code) << 28);
          lookup(ztag[code], 32'h0002_0404, 0, u[0], a, 32'(code) << 26);
        end

    // R8 zone 15 lives in the lowest two bits
    lookup("R8", 32'h0100_0000, 0, 1, 1, 32'h0000_0003);
    lookup("R8", 32'h0100_0000, 0, 1, 1, 32'hFFFF_FFFC);
    lookup("R8", 32'h0700_0000, 9, 1, 0, 32'h3FFF_FFFF);
    lookup("R8", 32'h0700_0000, 9, 1, 0, 32'hC000_0000);

    // R13 write and lookup in the same cycle: old contents seen
    set_wr(0, 0, 5, 32'h0001_0000, 32'h8000_0000, 1, 1, 1, 0);
    set_req(32'h0001_0020, 5, 0, 0, 32'h5555_5555);
    step("R13");
    lookup("R13", 32'h0001_0020, 5, 0, 0, 32'h5555_5555);
    set_wr(0, 1, 5, 32'h0001_0000, 32'h8100_0000, 1, 1, 1, 1);
    set_req(32'h0001_0020, 5, 0, 1, 32'h5555_5555);
    step("R13");
    lookup("R13", 32'h0001_0020, 5, 0, 1, 32'h5555_5555);

    // mixed sweep over all entries
    for (int k = 0; k < 300; k++) begin
      logic [31:0] base;
      case (k % 6)
        0: base = 32'h0001_0000;
        1: base = 32'h0002_0400;
        2: base = 32'h0030_0000;
        3: base = 32'h0100_0000;
        4: base = 32'h0700_0000;
        default: base = 32'h0050_0000;
      endcase
      lookup("R6", base + 32'((k * 37) % 1024), k % 11, k[1], k % 4,
             32'(k) * 32'h9E37_79B9);
    end
    step("R1");

    done = 1;
    summary();
    $finish;
  end

endmodule